// File: doc/BRIEF.md
# Dual-Mode Reference Divider

This block makes the reference-side comparison pulse for a frequency synthesizer's phase comparator. It counts one of two source clocks, each given as a clock enable in the system clock domain. One is a slow crystal tick and the other is a fast external reference tick. A select input chooses the source, and it also sets how the one 17-bit setting word is read.

With the crystal source chosen, the word is a direct modulus R, and one pulse comes out every R crystal ticks. With the external source chosen, the word is split into a 13-bit main count (upper bits) and a 4-bit swallow count (lower bits). A 16/17 prescaler then divides by 16·main + swallow. Each mode keeps its own last accepted setting. A word that is illegal for the active mode raises an error flag and is not taken. A low run input holds the counters at the start of a period. Changing the select input restarts the count, so the first period after the change is a full period.

Top module: `ref_divider`

## Requirements
- R1: With `xtal_sel` = 1, a pulse appears once every M ticks of `xtal_ce`, where M is the held direct modulus. Ticks of `ext_ce` have no effect in this mode.
- R2: With `xtal_sel` = 0, a pulse appears once every 16·NR + AR ticks of `ext_ce`. NR is held setting bits [16:4] and AR is bits [3:0]. Ticks of `xtal_ce` have no effect in this mode.
- R3: In direct mode a setting is legal when it is even and at least 6. An odd setting, or one below 6, drives `set_err` high in the following cycle, and the held direct modulus stays unchanged.
- R4: In swallow mode a setting is legal when NR is at least 17, which also makes NR greater than AR. Otherwise `set_err` is high in the following cycle, and the held swallow pair stays unchanged.
- R5: `ref_pulse` is registered and lasts exactly one clock cycle. It is high in the cycle after the selected source's tick that completes the period.
- R6: While `run` is low, no pulse is produced and the counters rest at the start of a period. The first period after `run` returns high is a full period.
- R7: A change of `xtal_sel` restarts the count. A tick in the cycle of the change is not counted, and the first period after the change is a full period.
- R8: After reset, `ref_pulse` and `set_err` are 0. The held settings are 6 for direct mode and NR = 17, AR = 0 (272) for swallow mode.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High to divide, low for standby |
| xtal_sel | input | 1 | 1 selects the crystal tick and direct mode; 0 selects the external tick and swallow mode |
| xtal_ce | input | 1 | Crystal source tick, one clock wide |
| ext_ce | input | 1 | External source tick, one clock wide |
| div_set | input | 17 | Setting word |
| ref_pulse | output | 1 | Reference pulse, one clock wide |
| set_err | output | 1 | Current setting is illegal for the active mode |

## Verification
Both source ticks are driven at random densities from 40 to 100 percent and independently of each other. This shows that only the selected source advances the count and that gaps between ticks do not change the period. The direct mode is tried at its smallest modulus 6 and at several random even values. The swallow mode is tried at 272, at the largest swallow count 15, and at random pairs. A wrong split between the 16-tick and 17-tick prescaler cycles would show up as a period error.

Illegal words are written in the middle of a run: odd values, small values, and a main count below 17. The periods that follow must keep the old modulus. Mode switches are made in the middle of a period with a tick in the switch cycle, and standby gaps are inserted. These show whether the restart leaves a partial or a full first period.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    typedef enum logic {
        SRC_EXT  = 1'b0,
        SRC_XTAL = 1'b1
    } src_e;

    localparam int unsigned DEF_SET_W   = 17;
    localparam int unsigned DEF_SWAL_W  = 4;
    localparam int unsigned DEF_DIR_MIN = 6;

endpackage

// File: rtl/refdiv_hold.sv
module refdiv_hold #(
    parameter int unsigned SET_W   = refdiv_pkg::DEF_SET_W,
    parameter int unsigned SWAL_W  = refdiv_pkg::DEF_SWAL_W,
    parameter int unsigned DIR_MIN = refdiv_pkg::DEF_DIR_MIN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_xtal,
    input  logic [SET_W-1:0]          setting,
    output logic [SET_W-1:0]          dir_mod,
    output logic [SET_W-SWAL_W-1:0]   main_set,
    output logic [SWAL_W-1:0]         swal_set,
    output logic                      err
);
    localparam int unsigned MAIN_W   = SET_W - SWAL_W;
    localparam int unsigned MAIN_MIN = (2 ** SWAL_W) + 1;
    localparam logic [SET_W-1:0] DIR_RST = SET_W'(DIR_MIN);
    localparam logic [SET_W-1:0] SW_RST  = {MAIN_W'(MAIN_MIN), SWAL_W'(0)};

    typedef struct packed {
        logic [SET_W-1:0] dir;
        logic [SET_W-1:0] sw;
        logic             err;
    } hold_t;

    hold_t hold_d, hold_q;

    logic              dir_ok, sw_ok;
    logic [MAIN_W-1:0] main_in;
    logic [SWAL_W-1:0] swal_in;

    always_comb begin
        main_in = setting[SET_W-1:SWAL_W];
        swal_in = setting[SWAL_W-1:0];
        dir_ok  = !setting[0] && (setting >= DIR_RST);
        sw_ok   = (main_in >= MAIN_W'(MAIN_MIN)) && (main_in > MAIN_W'(swal_in));

        hold_d = hold_q;
        if (sel_xtal) begin
            if (dir_ok) hold_d.dir = setting;
            hold_d.err = !dir_ok;
        end else begin
            if (sw_ok) hold_d.sw = setting;
            hold_d.err = !sw_ok;
        end

        dir_mod  = hold_d.dir;
        main_set = hold_d.sw[SET_W-1:SWAL_W];
        swal_set = hold_d.sw[SWAL_W-1:0];
        err      = hold_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.dir <= DIR_RST;
            hold_q.sw  <= SW_RST;
            hold_q.err <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/refdiv_direct.sv
module refdiv_direct #(
    parameter int unsigned SET_W = refdiv_pkg::DEF_SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [SET_W-1:0] modulus,
    output logic             term
);
    typedef struct packed {
        logic [SET_W-1:0] cnt;
    } dir_t;

    dir_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        term = tick && !restart && (st_q.cnt == '0);
        if (restart) begin
            st_d.cnt = modulus - SET_W'(1);
        end else if (tick) begin
            if (st_q.cnt == '0) st_d.cnt = modulus - SET_W'(1);
            else                st_d.cnt = st_q.cnt - SET_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/refdiv_swallow.sv
module refdiv_swallow #(
    parameter int unsigned MAIN_W = refdiv_pkg::DEF_SET_W - refdiv_pkg::DEF_SWAL_W,
    parameter int unsigned SWAL_W = refdiv_pkg::DEF_SWAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [MAIN_W-1:0] main_set,
    input  logic [SWAL_W-1:0] swal_set,
    output logic              term
);
    localparam int unsigned PRE_W = SWAL_W + 1;
    // a prescaler cycle of 2**SWAL_W + 1 ticks counts down from PRE_LONG
    localparam logic [PRE_W-1:0] PRE_LONG  = PRE_W'(2 ** SWAL_W);
    localparam logic [PRE_W-1:0] PRE_SHORT = PRE_W'((2 ** SWAL_W) - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MAIN_W-1:0] main;
        logic [SWAL_W-1:0] swal;
    } sw_t;

    sw_t st_d, st_q;
    sw_t start;
    logic [SWAL_W-1:0] swal_next;

    always_comb begin
        start.main = main_set - MAIN_W'(1);
        start.swal = swal_set;
        start.pre  = (swal_set != '0) ? PRE_LONG : PRE_SHORT;

        swal_next = (st_q.swal != '0) ? st_q.swal - SWAL_W'(1) : st_q.swal;
        term      = tick && !restart && (st_q.pre == '0) && (st_q.main == '0);

        st_d = st_q;
        if (restart) begin
            st_d = start;
        end else if (tick) begin
            if (st_q.pre == '0) begin
                if (st_q.main == '0) begin
                    st_d = start;
                end else begin
                    st_d.main = st_q.main - MAIN_W'(1);
                    st_d.swal = swal_next;
                    st_d.pre  = (swal_next != '0) ? PRE_LONG : PRE_SHORT;
                end
            end else begin
                st_d.pre = st_q.pre - PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int unsigned SET_W   = refdiv_pkg::DEF_SET_W,
    parameter int unsigned SWAL_W  = refdiv_pkg::DEF_SWAL_W,
    parameter int unsigned DIR_MIN = refdiv_pkg::DEF_DIR_MIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             xtal_sel,
    input  logic             xtal_ce,
    input  logic             ext_ce,
    input  logic [SET_W-1:0] div_set,
    output logic             ref_pulse,
    output logic             set_err
);
    import refdiv_pkg::*;

    localparam int unsigned MAIN_W = SET_W - SWAL_W;

    typedef struct packed {
        src_e src;
        logic armed;
        logic pulse;
    } top_t;

    top_t top_d, top_q;

    logic [SET_W-1:0]  dir_mod;
    logic [MAIN_W-1:0] main_set;
    logic [SWAL_W-1:0] swal_set;
    logic              restart;
    logic              dir_term, sw_term;
    src_e              src_now;

    refdiv_hold #(
        .SET_W  (SET_W),
        .SWAL_W (SWAL_W),
        .DIR_MIN(DIR_MIN)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_xtal(xtal_sel),
        .setting (div_set),
        .dir_mod (dir_mod),
        .main_set(main_set),
        .swal_set(swal_set),
        .err     (set_err)
    );

    refdiv_direct #(
        .SET_W(SET_W)
    ) u_direct (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart || (src_now != SRC_XTAL)),
        .tick   (xtal_ce),
        .modulus(dir_mod),
        .term   (dir_term)
    );

    refdiv_swallow #(
        .MAIN_W(MAIN_W),
        .SWAL_W(SWAL_W)
    ) u_swallow (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart || (src_now != SRC_EXT)),
        .tick    (ext_ce),
        .main_set(main_set),
        .swal_set(swal_set),
        .term    (sw_term)
    );

    always_comb begin
        src_now     = src_e'(xtal_sel);
        restart     = !run || !top_q.armed || (src_now != top_q.src);
        top_d       = top_q;
        top_d.src   = src_now;
        top_d.armed = 1'b1;
        top_d.pulse = (src_now == SRC_XTAL) ? dir_term : sw_term;
        ref_pulse   = top_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.src   <= SRC_EXT;
            top_q.armed <= 1'b0;
            top_q.pulse <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

endmodule

// File: rtl/ref_divider_chk.sv
module ref_divider_chk #(
    parameter int unsigned SET_W  = refdiv_pkg::DEF_SET_W,
    parameter int unsigned SWAL_W = refdiv_pkg::DEF_SWAL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             xtal_sel,
    input logic             xtal_ce,
    input logic             ext_ce,
    input logic [SET_W-1:0] div_set,
    input logic             ref_pulse,
    input logic             set_err
);
    localparam int unsigned MAIN_W   = SET_W - SWAL_W;
    localparam int unsigned MAIN_MIN = (2 ** SWAL_W) + 1;

    logic sel_p, seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_p <= 1'b0;
            seen  <= 1'b0;
        end else begin
            sel_p <= xtal_sel;
            seen  <= 1'b1;
        end
    end

    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    a_r5_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> ($past(xtal_sel) ? $past(xtal_ce) : $past(ext_ce)));

    a_r6_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ref_pulse);

    a_r7_switch_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && (xtal_sel != sel_p)) |=> !ref_pulse);

    a_r3_odd_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal_sel && div_set[0]) |=> set_err);

    a_r4_low_main_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (!xtal_sel && (div_set[SET_W-1:SWAL_W] < MAIN_W'(MAIN_MIN))) |=> set_err);

endmodule

bind ref_divider ref_divider_chk #(
    .SET_W (SET_W),
    .SWAL_W(SWAL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .xtal_sel (xtal_sel),
    .xtal_ce  (xtal_ce),
    .ext_ce   (ext_ce),
    .div_set  (div_set),
    .ref_pulse(ref_pulse),
    .set_err  (set_err)
);

// File: tb/tb_ref_divider.sv
module tb_ref_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        xtal_sel = 1'b1;
    logic        xtal_ce = 1'b0;
    logic        ext_ce = 1'b0;
    logic [16:0] div_set = 17'd1;
    logic        ref_pulse;
    logic        set_err;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    int pulses = 0;
    bit last_pulse = 1'b0;
    bit done = 1'b0;
    int held_dir = 6;
    int held_sw = (17 << 4);

    always #10 clk = ~clk;

    ref_divider dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .xtal_sel (xtal_sel),
        .xtal_ce  (xtal_ce),
        .ext_ce   (ext_ce),
        .div_set  (div_set),
        .ref_pulse(ref_pulse),
        .set_err  (set_err)
    );

    function automatic bit dir_ok(input int v);
        return (v % 2 == 0) && (v >= 6);
    endfunction

    function automatic bit sw_ok(input int v);
        return ((v >> 4) >= 17) && ((v >> 4) > (v & 15));
    endfunction

    function automatic int sw_mod(input int v);
        return 16 * (v >> 4) + (v & 15);
    endfunction

    function automatic int cur_mod();
        return xtal_sel ? held_dir : sw_mod(held_sw);
    endfunction

    function automatic bit exp_err();
        return xtal_sel ? !dir_ok(int'(div_set)) : !sw_ok(int'(div_set));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // change inputs at a falling edge; mirror the held settings
    task automatic drive(input bit nsel, input bit nrun, input int nset);
        xtal_sel = nsel;
        run      = nrun;
        div_set  = 17'(nset);
        if (nsel && dir_ok(nset))  held_dir = nset;
        if (!nsel && sw_ok(nset))  held_sw  = nset;
    endtask

    // one clock: drive ticks, let the edge pass, judge at the falling edge
    task automatic cyc(input int dens, input bit restart_cyc);
        bit t;
        if (restart_cyc) begin
            xtal_ce = 1'b1;
            ext_ce  = 1'b1;
        end else begin
            xtal_ce = ($urandom_range(99) < dens);
            ext_ce  = ($urandom_range(99) < dens);
        end
        @(posedge clk);
        t = xtal_sel ? xtal_ce : ext_ce;
        @(negedge clk);
        chk(set_err == exp_err(), xtal_sel ? "R3" : "R4", int'(set_err), int'(exp_err()));
        if (!run || restart_cyc) begin
            chk(!ref_pulse, run ? "R7" : "R6", int'(ref_pulse), 0);
            tick_cnt = 0;
        end else begin
            if (t) tick_cnt++;
            if (ref_pulse) begin
                chk(t, "R5", int'(t), 1);
                chk(!last_pulse, "R5", int'(last_pulse), 0);
                chk(tick_cnt == cur_mod(), xtal_sel ? "R1" : "R2", tick_cnt, cur_mod());
                tick_cnt = 0;
                pulses++;
            end else if (tick_cnt >= cur_mod()) begin
                chk(1'b0, xtal_sel ? "R1" : "R2", tick_cnt, cur_mod());
                tick_cnt = 0;
            end
        end
        last_pulse = ref_pulse;
    endtask

    task automatic run_phase(input int dens);
        int start = pulses;
        int n = (3 * cur_mod() * 100) / dens + 40;
        repeat (n) cyc(dens, 1'b0);
        chk(pulses > start, xtal_sel ? "R1" : "R2", pulses - start, 1);
    endtask

    // load a setting through a standby cycle, then run
    task automatic apply(input bit nsel, input int nset, input int dens);
        drive(nsel, 1'b0, nset);
        cyc(dens, 1'b0);
        drive(nsel, 1'b1, nset);
        run_phase(dens);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4177));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ref_pulse == 1'b0, "R8", int'(ref_pulse), 0);
        chk(set_err == 1'b0, "R8", int'(set_err), 0);
        rst_n = 1'b1;

        // R8: illegal word in both modes, defaults must govern
        drive(1'b1, 1'b1, 1);
        cyc(0, 1'b1);
        run_phase(70);
        // R7: switch to swallow mode with a tick in the switch cycle
        drive(1'b0, 1'b1, 1);
        cyc(0, 1'b1);
        run_phase(80);

        // R1 corners
        apply(1'b1, 6, 100);
        apply(1'b1, 8, 55);
        // R2 corners: minimum, max swallow count, mixed
        apply(1'b0, (17 << 4) | 15, 100);
        apply(1'b0, (30 << 4) | 9, 60);

        // R3: illegal direct words mid-run keep modulus 10
        apply(1'b1, 10, 75);
        drive(1'b1, 1'b1, (17 << 4) | 1);
        run_phase(75);
        drive(1'b1, 1'b1, 4);
        run_phase(75);

        // R4: main count below 17 mid-run keeps 307
        apply(1'b0, (19 << 4) | 3, 90);
        drive(1'b0, 1'b1, (16 << 4) | 3);
        run_phase(90);

        // R6: standby with ticks, then a full first period
        drive(1'b0, 1'b0, (16 << 4) | 3);
        repeat (60) cyc(80, 1'b0);
        drive(1'b0, 1'b1, (16 << 4) | 3);
        run_phase(80);

        // R7: switch in mid-period to direct mode (odd word, held 10)
        repeat (100) cyc(90, 1'b0);
        drive(1'b1, 1'b1, (19 << 4) | 3);
        cyc(0, 1'b1);
        run_phase(90);

        // random settings, entered by standby or by a mode switch
        for (int i = 0; i < 16; i++) begin
            bit nsel = 1'($urandom_range(1));
            int dens = int'($urandom_range(100, 40));
            int nset;
            if (nsel) nset = 2 * int'($urandom_range(100, 3));
            else      nset = (int'($urandom_range(22, 17)) << 4) | int'($urandom_range(15));
            if ($urandom_range(1) == 1 && nsel != xtal_sel) begin
                drive(nsel, 1'b1, nset);
                cyc(0, 1'b1);
                run_phase(dens);
            end else begin
                apply(nsel, nset, dens);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule